// File: doc/BRIEF.md
# Moving Edge Detector

The block marks pixels that sit on the outline of a moving object in a grayscale video stream. Each clock it can take one pixel of the current frame together with the pixel at the same position in the previous frame, both in raster order. It holds two rows of the current frame internally. From these rows it builds a 3x3 neighbourhood and computes a Sobel gradient magnitude. It also compares the absolute difference between the current and previous pixel against a threshold. A pixel is flagged only when both its gradient test and its difference test pass.

Frame storage lives outside the block. The external buffer replays the previous frame beside the live one. Downstream logic receives one result bit per input beat, with valid and start-of-frame / end-of-line markers carried through the pipeline. At the default 320x240 size a frame needs 76,800 beats. This fits well inside a 34 ms frame budget at any clock above a few MHz.

Top module: `moving_edge_detect`

## Requirements
- R1: While rst_ni is low, and for the first three rising edges after it rises, valid_o, sof_o, eol_o and edge_o are 0.
- R2: valid_o, sof_o and eol_o equal valid_i, sof_i and eol_i as sampled three rising edges earlier. An input beat sampled at edge k shows on the outputs after edge k+2.
- R3: The bit emitted with the markers of the input beat at row r, column c (counted from 0, with sof_i marking row 0 column 0 and eol_i ending a row) is the result for the pixel at row r-1, column c-1.
- R4: That bit is 0 whenever r < 2 or c < 2. This covers every result for the outer ring of the frame and every position outside it.
- R5: The edge test passes when |Gx| + |Gy| is strictly greater than edge_thr_i. Gx is the right column minus the left column of the 3x3 neighbourhood, weighted 1,2,1 from top to bottom. Gy is the bottom row minus the top row, weighted 1,2,1 from left to right.
- R6: The motion test passes when |cur - prev| at the centre pixel is strictly greater than motion_thr_i.
- R7: edge_o is 1 only when both tests pass. A strong gradient with no frame change gives 0, and a frame change with no gradient gives 0.
- R8: The magnitude is exact over its full range of 0 to 2040 for 8-bit pixels, with no wrap.
- R9: Cycles with valid_i low do not advance the pipeline contents. A stream with idle gaps gives the same bits as the same stream without gaps.
- R10: sof_i restarts the coordinates, so back-to-back frames are processed with no reset between them.
- R11: edge_o is 0 in every cycle in which valid_o is 0.

Both thresholds are held stable while a frame is streamed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input beat present |
| sof_i | input | 1 | Beat is row 0, column 0 |
| eol_i | input | 1 | Beat is the last of its row |
| cur_pix_i | input | PIX_W | Current-frame pixel |
| prev_pix_i | input | PIX_W | Previous-frame pixel, same position |
| edge_thr_i | input | PIX_W+3 | Gradient magnitude threshold |
| motion_thr_i | input | PIX_W | Frame-difference threshold |
| valid_o | output | 1 | Result beat present |
| sof_o | output | 1 | Delayed sof_i |
| eol_o | output | 1 | Delayed eol_i |
| edge_o | output | 1 | Moving-edge bit |

## Verification
Four properties are checked on every cycle:
- the fixed three-edge delay of valid and both markers;
- quiet outputs right after reset;
- edge_o never set without valid_o;
- a zero bit for the first two columns and rows of the output stream, counted from the output markers themselves.

The value of each interior bit can only be judged by the bench scenarios. These compare every result against a software model of the gradient, difference and AND. They include threshold-equal cases, the large diagonal magnitude, idle gaps and two frames in a row.

// File: rtl/med_pkg.sv
package med_pkg;
  localparam int KERNEL = 3;

  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
    logic inner;
  } mark_t;
endpackage

// File: rtl/med_line_window.sv
module med_line_window #(
  parameter int IMG_W = 320,
  parameter int PIX_W = 8,
  parameter int COL_W = $clog2(IMG_W)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 shift_i,
  input  logic [COL_W-1:0]                     col_i,
  input  logic [PIX_W-1:0]                     pix_i,
  output logic [med_pkg::KERNEL-1:0][med_pkg::KERNEL-1:0][PIX_W-1:0] win_o
);
  localparam int K = med_pkg::KERNEL;

  logic [PIX_W-1:0] row_m1 [IMG_W];
  logic [PIX_W-1:0] row_m2 [IMG_W];
  logic [K-1:0][PIX_W-1:0] new_col;

  assign new_col[0] = row_m2[col_i];
  assign new_col[1] = row_m1[col_i];
  assign new_col[2] = pix_i;

  always_ff @(posedge clk_i) begin
    if (shift_i) begin
      row_m2[col_i] <= row_m1[col_i];
      row_m1[col_i] <= pix_i;
    end
  end

  // win_o[row][col]: row 0 top, col 0 left (oldest)
  for (genvar r = 0; r < K; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_o[r] <= '0;
      end else if (shift_i) begin
        for (int c = 0; c < K-1; c++) win_o[r][c] <= win_o[r][c+1];
        win_o[r][K-1] <= new_col[r];
      end
    end
  end
endmodule

// File: rtl/med_sobel.sv
module med_sobel #(
  parameter int PIX_W = 8,
  parameter int MAG_W = PIX_W + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [med_pkg::KERNEL-1:0][med_pkg::KERNEL-1:0][PIX_W-1:0] win_i,
  output logic [MAG_W-1:0]     mag_o
);
  localparam int GW = PIX_W + 4;   // signed, holds +/- 4*max
  localparam int AW = PIX_W + 2;   // holds 4*max

  function automatic logic signed [GW-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed(GW'(p));
  endfunction

  logic signed [GW-1:0] gx, gy;
  logic [AW-1:0] ax_q, ay_q;

  always_comb begin
    gx = (ext(win_i[0][2]) + (ext(win_i[1][2]) <<< 1) + ext(win_i[2][2]))
       - (ext(win_i[0][0]) + (ext(win_i[1][0]) <<< 1) + ext(win_i[2][0]));
    gy = (ext(win_i[2][0]) + (ext(win_i[2][1]) <<< 1) + ext(win_i[2][2]))
       - (ext(win_i[0][0]) + (ext(win_i[0][1]) <<< 1) + ext(win_i[0][2]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ax_q <= '0;
      ay_q <= '0;
    end else begin
      ax_q <= AW'(gx[GW-1] ? -gx : gx);
      ay_q <= AW'(gy[GW-1] ? -gy : gy);
    end
  end

  assign mag_o = MAG_W'(ax_q) + MAG_W'(ay_q);
endmodule

// File: rtl/med_motion.sv
module med_motion #(
  parameter int IMG_W = 320,
  parameter int PIX_W = 8,
  parameter int COL_W = $clog2(IMG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] prev_i,
  input  logic [PIX_W-1:0] thr_i,
  output logic             motion_o
);
  // one bit per column: result delayed by one row, then one beat
  logic             mbits [IMG_W];
  logic             hold_q;
  logic [PIX_W-1:0] diff;
  logic             hit;

  assign diff = (cur_i >= prev_i) ? (cur_i - prev_i) : (prev_i - cur_i);
  assign hit  = diff > thr_i;

  always_ff @(posedge clk_i) begin
    if (shift_i) mbits[col_i] <= hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      motion_o <= 1'b0;
    end else if (shift_i) begin
      motion_o <= hold_q;
      hold_q   <= mbits[col_i];
    end
  end
endmodule

// File: rtl/moving_edge_detect.sv
module moving_edge_detect import med_pkg::*; #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic [PIX_W-1:0] cur_pix_i,
  input  logic [PIX_W-1:0] prev_pix_i,
  input  logic [PIX_W+2:0] edge_thr_i,
  input  logic [PIX_W-1:0] motion_thr_i,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eol_o,
  output logic             edge_o
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam int MAG_W = PIX_W + 3;

  logic [COL_W-1:0] col_q, col_cur;
  logic [ROW_W-1:0] row_q, row_cur;
  logic             inner;

  assign col_cur = sof_i ? '0 : col_q;
  assign row_cur = sof_i ? '0 : row_q;
  assign inner   = (row_cur >= ROW_W'(2)) && (col_cur >= COL_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid_i) begin
      if (eol_i || col_cur == COL_W'(IMG_W-1)) begin
        col_q <= '0;
        row_q <= (row_cur == ROW_W'(IMG_H-1)) ? row_cur : row_cur + 1'b1;
      end else begin
        col_q <= col_cur + 1'b1;
        row_q <= row_cur;
      end
    end
  end

  logic [KERNEL-1:0][KERNEL-1:0][PIX_W-1:0] win;
  logic [MAG_W-1:0] mag;
  logic             motion;

  med_line_window #(.IMG_W(IMG_W), .PIX_W(PIX_W), .COL_W(COL_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .col_i   (col_cur),
    .pix_i   (cur_pix_i),
    .win_o   (win)
  );

  med_sobel #(.PIX_W(PIX_W), .MAG_W(MAG_W)) u_sobel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win),
    .mag_o  (mag)
  );

  med_motion #(.IMG_W(IMG_W), .PIX_W(PIX_W), .COL_W(COL_W)) u_motion (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (valid_i),
    .col_i    (col_cur),
    .cur_i    (cur_pix_i),
    .prev_i   (prev_pix_i),
    .thr_i    (motion_thr_i),
    .motion_o (motion)
  );

  mark_t mk1_q, mk2_q;
  logic  mot2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mk1_q   <= '0;
      mk2_q   <= '0;
      mot2_q  <= 1'b0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      edge_o  <= 1'b0;
    end else begin
      mk1_q   <= '{valid: valid_i, sof: sof_i, eol: eol_i, inner: valid_i & inner};
      mk2_q   <= mk1_q;
      mot2_q  <= motion;
      valid_o <= mk2_q.valid;
      sof_o   <= mk2_q.sof;
      eol_o   <= mk2_q.eol;
      edge_o  <= mk2_q.valid & mk2_q.inner & mot2_q & (mag > edge_thr_i);
    end
  end
endmodule

// File: rtl/moving_edge_detect_chk.sv
module moving_edge_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic eol_i,
  input logic valid_o,
  input logic sof_o,
  input logic eol_o,
  input logic edge_o
);
  logic [1:0]  since_rst;
  logic [15:0] oc_q, or_q, o_col, o_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  assign o_col = sof_o ? '0 : oc_q;
  assign o_row = sof_o ? '0 : or_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= '0;
      or_q <= '0;
    end else if (valid_o) begin
      if (eol_o) begin
        oc_q <= '0;
        or_q <= (o_row == 16'hFFFF) ? o_row : o_row + 1'b1;
      end else begin
        oc_q <= (o_col == 16'hFFFF) ? o_col : o_col + 1'b1;
        or_q <= o_row;
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd3) |-> (!valid_o && !sof_o && !eol_o && !edge_o));

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  a_r2_marker_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (sof_o == $past(sof_i, 3) && eol_o == $past(eol_i, 3)));

  a_r4_border_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (o_col < 16'd2 || o_row < 16'd2)) |-> !edge_o);

  a_r11_no_bit_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !edge_o);
endmodule

bind moving_edge_detect moving_edge_detect_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sof_i   (sof_i),
  .eol_i   (eol_i),
  .valid_o (valid_o),
  .sof_o   (sof_o),
  .eol_o   (eol_o),
  .edge_o  (edge_o)
);

// File: tb/tb_moving_edge_detect.sv
module tb_moving_edge_detect;
  localparam int W = 8;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, sof_i = 1'b0, eol_i = 1'b0;
  logic [7:0] cur_pix_i = '0, prev_pix_i = '0;
  logic [10:0] edge_thr_i = '0;
  logic [7:0] motion_thr_i = '0;
  logic       valid_o, sof_o, eol_o, edge_o;

  always #4 clk = ~clk;

  moving_edge_detect #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i), .eol_i(eol_i),
    .cur_pix_i(cur_pix_i), .prev_pix_i(prev_pix_i), .edge_thr_i(edge_thr_i),
    .motion_thr_i(motion_thr_i), .valid_o(valid_o), .sof_o(sof_o), .eol_o(eol_o),
    .edge_o(edge_o)
  );

  typedef struct packed {
    int stamp;
    bit e;
    bit s;
    bit l;
  } exp_t;

  exp_t  expq[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  int    ones_seen = 0, ones_exp = 0;
  string tag = "R3";
  bit    done = 1'b0;
  int    cur_f [H][W];
  int    prev_f[H][W];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic bit ref_bit(input int r, input int c);
    int cr, cc, gx, gy;
    if (r < 2 || c < 2) return 1'b0;
    cr = r - 1;
    cc = c - 1;
    gx = (cur_f[cr-1][cc+1] + 2*cur_f[cr][cc+1] + cur_f[cr+1][cc+1])
       - (cur_f[cr-1][cc-1] + 2*cur_f[cr][cc-1] + cur_f[cr+1][cc-1]);
    gy = (cur_f[cr+1][cc-1] + 2*cur_f[cr+1][cc] + cur_f[cr+1][cc+1])
       - (cur_f[cr-1][cc-1] + 2*cur_f[cr-1][cc] + cur_f[cr-1][cc+1]);
    return (iabs(gx) + iabs(gy) > int'(edge_thr_i)) &&
           (iabs(cur_f[cr][cc] - prev_f[cr][cc]) > int'(motion_thr_i));
  endfunction

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected valid_o", 1, 0);
      end else begin
        exp_t x;
        x = expq.pop_front();
        chk(edge_o == x.e, tag, "edge_o", int'(edge_o), int'(x.e));
        chk(sof_o == x.s && eol_o == x.l, "R2", "markers sof*2+eol",
            int'(sof_o)*2 + int'(eol_o), int'(x.s)*2 + int'(x.l));
        chk(cyc == x.stamp + 3, "R2", "latency cycle", cyc, x.stamp + 3);
      end
      if (edge_o) ones_seen++;
    end else if (rst_ni) begin
      chk(edge_o == 1'b0, "R11", "edge_o without valid", int'(edge_o), 0);
    end
  end

  task automatic drive_frame(input bit stall);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        exp_t x;
        if (stall && $urandom_range(0, 2) == 0) begin
          valid_i = 1'b0; sof_i = 1'b0; eol_i = 1'b0;
          @(negedge clk);
        end
        valid_i    = 1'b1;
        sof_i      = (r == 0 && c == 0);
        eol_i      = (c == W - 1);
        cur_pix_i  = 8'(cur_f[r][c]);
        prev_pix_i = 8'(prev_f[r][c]);
        x.stamp = cyc;
        x.e = ref_bit(r, c);
        x.s = sof_i;
        x.l = eol_i;
        if (x.e) ones_exp++;
        expq.push_back(x);
        @(negedge clk);
      end
    end
    valid_i = 1'b0; sof_i = 1'b0; eol_i = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 50 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, req, "results outstanding", expq.size(), 0);
    chk(ones_seen == ones_exp, req, "count of set bits", ones_seen, ones_exp);
  endtask

  task automatic start(input string req, input int et, input int mt);
    tag = req;
    edge_thr_i = 11'(et);
    motion_thr_i = 8'(mt);
    ones_seen = 0;
    ones_exp = 0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk({valid_o, sof_o, eol_o, edge_o} == 4'b0, "R1", "outputs in reset",
        int'({valid_o, sof_o, eol_o, edge_o}), 0);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk({valid_o, sof_o, eol_o, edge_o} == 4'b0, "R1", "outputs after reset",
          int'({valid_o, sof_o, eol_o, edge_o}), 0);
    end
  endtask

  // strong vertical edge but prev == cur: no output bits
  task automatic t_edge_no_motion();
    start("R7", 100, 10);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = (c < 4) ? 20 : 200;
        prev_f[r][c] = cur_f[r][c];
      end
    drive_frame(1'b0);
    drain("R7");
    chk(ones_seen == 0, "R7", "bits with no motion", ones_seen, 0);
  endtask

  // large change everywhere but flat image: no output bits
  task automatic t_motion_no_edge();
    start("R7", 10, 10);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = 120;
        prev_f[r][c] = 10;
      end
    drive_frame(1'b0);
    drain("R7");
    chk(ones_seen == 0, "R7", "bits with no gradient", ones_seen, 0);
  endtask

  // moving step: bits only at interior centres next to the step (R3, R4)
  task automatic t_moving_step();
    start("R3", 100, 10);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = (c < 4) ? 20 : 200;
        prev_f[r][c] = 0;
      end
    drive_frame(1'b0);
    drain("R4");
    chk(ones_exp == 2 * (H - 2), "R3", "model bit count", ones_exp, 2 * (H - 2));
  endtask

  // step of 10 gives magnitude 40 at centres next to it
  task automatic t_edge_threshold(input int et);
    start("R5", et, 5);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = (c < 4) ? 50 : 60;
        prev_f[r][c] = 0;
      end
    drive_frame(1'b0);
    drain("R5");
  endtask

  // difference of exactly 30 everywhere
  task automatic t_motion_threshold(input int mt);
    start("R6", 50, mt);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = (c < 4) ? 40 : 230;
        prev_f[r][c] = cur_f[r][c] - 30;
      end
    drive_frame(1'b0);
    drain("R6");
  endtask

  // diagonal 0/255 split: magnitude reaches 1530, beyond 10 bits
  task automatic t_wide_magnitude(input int et);
    start("R8", et, 0);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = (r + c >= 6) ? 255 : 0;
        prev_f[r][c] = 0;
      end
    drive_frame(1'b0);
    drain("R8");
  endtask

  // two frames back to back with random idle gaps
  task automatic t_gaps_two_frames();
    start("R9", 200, 40);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        cur_f[r][c] = int'($urandom_range(0, 255));
        prev_f[r][c] = int'($urandom_range(0, 255));
      end
    drive_frame(1'b1);
    tag = "R10";
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        prev_f[r][c] = cur_f[r][c];
        cur_f[r][c] = (c + r > 5) ? int'($urandom_range(150, 255)) : int'($urandom_range(0, 80));
      end
    drive_frame(1'b1);
    drain("R10");
  endtask

  initial begin : main
    @(negedge clk);
    t_reset();
    t_edge_no_motion();
    t_motion_no_edge();
    t_moving_step();
    t_edge_threshold(40);
    chk(ones_seen == 0, "R5", "bits at threshold equal", ones_seen, 0);
    t_edge_threshold(39);
    chk(ones_seen > 0, "R5", "bits just under threshold", ones_seen, 1);
    t_motion_threshold(30);
    chk(ones_seen == 0, "R6", "bits at threshold equal", ones_seen, 0);
    t_motion_threshold(29);
    chk(ones_seen > 0, "R6", "bits just under threshold", ones_seen, 1);
    t_wide_magnitude(1529);
    chk(ones_seen > 0, "R8", "bits above 1529", ones_seen, 1);
    t_wide_magnitude(1530);
    t_gaps_two_frames();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule